// File: doc/BRIEF.md
# Shared GPIO Pin Mux and Event Router

This block controls a bank of general-purpose digital pins. Most of these pins share their control bytes with a display-segment driver, and a small number are dedicated GPIO pins. Each shared pin has a function-select bit that hands the pin to the segment driver or keeps it as GPIO. A GPIO pin is either an input or an output, and an output drives a value taken from a stored data bit.

Every pin also has a 3-bit resource selector. For a GPIO input, the selector can turn edges of the synchronized pin level into tick pulses for one of two external counters. It can also turn them into pulses on a high-priority or a low-priority interrupt line, on a chosen edge. Software reaches all control bytes through a byte-wide write port with a per-bit write mask and a combinational read port. This lets segment code and GPIO code update the same byte with a read-modify-write without disturbing each other.

The segment waveform generator, the counters and the interrupt controller sit outside this block. The block only produces enables, tick pulses and interrupt pulses.

Top module: `shared_gpio_mux`

## Requirements
- R1: While reset is high and in the first cycle after it, every control byte reads 0. Every pin is a GPIO input with pin_oe low and pin_out low. seg_en, cnt_tick, irq_hi and irq_lo are all 0.
- R2: For shared pin i, bit 7 of its configuration byte (address i) is the function select. A 1 hands the pin to segment drive: seg_en[i] goes high and pin_oe[i] stays low. A 0 makes the pin a GPIO.
- R3: The direction and data bits sit in different places for the two kinds of pin. For a shared pin, direction is bit 3 and data is bit 0 of its configuration byte. For dedicated pin j (pin NS+j, address NS+j), direction is bit 7 and data is bit 4. A direction of 1 means output and 0 means input. pin_oe is high exactly for GPIO outputs, and pin_out equals the data bit while pin_oe is high and is 0 otherwise.
- R4: A write changes only the byte bits whose wr_mask bit is 1, and all other bytes keep their values. A shared configuration byte stores all 8 bits. A dedicated byte stores bits 7, 4 and 2:0. A shared-pin selector byte (address NS+ND+i) stores bits 2:0. Unstored bits and addresses of 2*NS+ND and above read 0.
- R5: rd_data shows the stored byte, with one exception. For a pin that is a GPIO input, the data-bit position returns the synchronized pin level, which follows pin_in two clock edges later.
- R6: Selector values 2 and 3 send rising edges of the pin level to cnt_tick[0] and cnt_tick[1]. Values 0 and 1 route nothing.
- R7: Selector 4 sends rising edges to irq_hi. Selector 5 sends rising edges to irq_lo. Selector 6 sends falling edges to irq_hi. Selector 7 sends falling edges to irq_lo.
- R8: A pin in segment mode or configured as an output produces no tick and no interrupt, whatever its selector.
- R9: A pin_in change sampled at edge k produces a single-cycle event pulse after edge k+2. The event uses the configuration held before that edge. Pulses from pins that share a resource are ORed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NS+ND | Raw pin levels (asynchronous) |
| pin_oe | output | NS+ND | Output-driver enable per pin |
| pin_out | output | NS+ND | Driven value per pin |
| seg_en | output | NS | Shared pin handed to segment drive |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 8 | Write data |
| wr_mask | input | 8 | Per-bit write enable |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 8 | Read data (combinational) |
| cnt_tick | output | 2 | Counter clock tick pulses |
| irq_hi | output | 1 | High-priority interrupt pulse |
| irq_lo | output | 1 | Low-priority interrupt pulse |

## Verification
The assertions rely on a few conditions holding at the block's inputs:
- reset is held high from time zero for at least one edge;
- wr_addr is stable at the edge it is sampled;
- pin_in is treated as asynchronous, so the assertions make no claim on the raw level, only on the synchronized copies.

The bench drives pin_in, the write port and rd_addr one time unit after the falling edge, so every input is settled long before the rising edge. Register writes use random masks and addresses, including out-of-range ones. Pins toggle randomly under a mix of selectors, directions and segment settings, and some configuration changes land in the same cycle as edges in flight.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    typedef enum logic [2:0] {
        RS_NONE    = 3'd0,
        RS_RSVD    = 3'd1,
        RS_CNT0    = 3'd2,
        RS_CNT1    = 3'd3,
        RS_HI_RISE = 3'd4,
        RS_LO_RISE = 3'd5,
        RS_HI_FALL = 3'd6,
        RS_LO_FALL = 3'd7
    } res_sel_e;

    typedef struct packed {
        logic     seg;
        logic     dir;
        logic     dout;
        res_sel_e sel;
    } pin_ctrl_t;

    typedef struct packed {
        logic cnt1;
        logic cnt0;
        logic irq_hi;
        logic irq_lo;
    } evt_t;

    localparam int SH_DATA_BIT  = 0;
    localparam int SH_DIR_BIT   = 3;
    localparam int SH_FSEL_BIT  = 7;
    localparam int DED_DIR_BIT  = 7;
    localparam int DED_DATA_BIT = 4;
    localparam logic [7:0] SH_IMPL_MASK  = 8'hFF;
    localparam logic [7:0] DED_IMPL_MASK = 8'h97;
    localparam logic [7:0] SEL_IMPL_MASK = 8'h07;

    function automatic logic [7:0] merge_byte(input logic [7:0] old_v,
                                              input logic [7:0] new_v,
                                              input logic [7:0] mask,
                                              input logic [7:0] impl);
        logic [7:0] en;
        en = mask & impl;
        return (old_v & ~en) | (new_v & en);
    endfunction

    function automatic evt_t route_edge(input res_sel_e sel,
                                        input logic rise, input logic fall);
        evt_t e;
        e = '0;
        case (sel)
            RS_CNT0:    e.cnt0   = rise;
            RS_CNT1:    e.cnt1   = rise;
            RS_HI_RISE: e.irq_hi = rise;
            RS_LO_RISE: e.irq_lo = rise;
            RS_HI_FALL: e.irq_hi = fall;
            RS_LO_FALL: e.irq_lo = fall;
            default:    e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int NP = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] pin_raw,
    output logic [NP-1:0] lvl,
    output logic [NP-1:0] rise,
    output logic [NP-1:0] fall
);
    logic [NP-1:0] meta_q, lvl_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_raw;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl  = lvl_q;
    assign rise = lvl_q & ~prev_q;
    assign fall = ~lvl_q & prev_q;

    // R9: an edge pulse never lasts two cycles
    p_edge_single_r9: assert property (@(posedge clk) disable iff (rst)
        ((rise & $past(rise)) == '0) && ((fall & $past(fall)) == '0));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_mux_pkg::*;
#(
    parameter int NS = 8,
    parameter int ND = 2,
    parameter int AW = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            wr_mask,
    input  logic [AW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    input  logic [NS+ND-1:0]      pin_lvl,
    output pin_ctrl_t [NS+ND-1:0] ctrl
);
    localparam int NP      = NS + ND;
    localparam int SEL_BASE = NS + ND;

    logic [7:0] sh_cfg  [NS];
    logic [7:0] sh_sel  [NS];
    logic [7:0] ded_cfg [ND];

    for (genvar i = 0; i < NS; i++) begin : g_shared
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_cfg[i] <= '0;
                sh_sel[i] <= '0;
            end else if (wr_en) begin
                if (wr_addr == AW'(i))
                    sh_cfg[i] <= merge_byte(sh_cfg[i], wr_data, wr_mask, SH_IMPL_MASK);
                if (wr_addr == AW'(SEL_BASE + i))
                    sh_sel[i] <= merge_byte(sh_sel[i], wr_data, wr_mask, SEL_IMPL_MASK);
            end
        end

        assign ctrl[i] = '{seg:  sh_cfg[i][SH_FSEL_BIT],
                           dir:  sh_cfg[i][SH_DIR_BIT],
                           dout: sh_cfg[i][SH_DATA_BIT],
                           sel:  res_sel_e'(sh_sel[i][2:0])};

        // R4: a byte not addressed by a write keeps its value
        p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_addr == AW'(i)) |=> $stable(sh_cfg[i]));
    end

    for (genvar j = 0; j < ND; j++) begin : g_dedicated
        always_ff @(posedge clk) begin
            if (rst)
                ded_cfg[j] <= '0;
            else if (wr_en && wr_addr == AW'(NS + j))
                ded_cfg[j] <= merge_byte(ded_cfg[j], wr_data, wr_mask, DED_IMPL_MASK);
        end

        assign ctrl[NS+j] = '{seg:  1'b0,
                              dir:  ded_cfg[j][DED_DIR_BIT],
                              dout: ded_cfg[j][DED_DATA_BIT],
                              sel:  res_sel_e'(ded_cfg[j][2:0])};
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NS; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = sh_cfg[i];
                if (!sh_cfg[i][SH_FSEL_BIT] && !sh_cfg[i][SH_DIR_BIT])
                    rd_data[SH_DATA_BIT] = pin_lvl[i];
            end
            if (rd_addr == AW'(SEL_BASE + i))
                rd_data = sh_sel[i];
        end
        for (int j = 0; j < ND; j++) begin
            if (rd_addr == AW'(NS + j)) begin
                rd_data = ded_cfg[j];
                if (!ded_cfg[j][DED_DIR_BIT])
                    rd_data[DED_DATA_BIT] = pin_lvl[NS+j];
            end
        end
    end

    // R4: unimplemented selector bits never become set
    p_sel_impl_r4: assert property (@(posedge clk) disable iff (rst)
        (sh_sel[0] & ~SEL_IMPL_MASK) == '0);

    logic unused_np;
    assign unused_np = (NP == 0);
endmodule

// File: rtl/gpio_event_router.sv
module gpio_event_router
    import gpio_mux_pkg::*;
#(
    parameter int NP = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pin_ctrl_t [NP-1:0]    ctrl,
    input  logic [NP-1:0]         rise,
    input  logic [NP-1:0]         fall,
    output evt_t                  evt_q
);
    evt_t evt_d;

    always_comb begin
        evt_d = '0;
        for (int i = 0; i < NP; i++) begin
            if (!ctrl[i].seg && !ctrl[i].dir)
                evt_d = evt_t'(evt_d | route_edge(ctrl[i].sel, rise[i], fall[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_d;
    end

    // R9: every event pulse is backed by an edge seen one cycle earlier
    p_event_has_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (evt_q != '0) |-> $past((rise | fall) != '0));
endmodule

// File: rtl/shared_gpio_mux.sv
module shared_gpio_mux
    import gpio_mux_pkg::*;
#(
    parameter int NS = 8,
    parameter int ND = 2,
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NS+ND-1:0] pin_in,
    output logic [NS+ND-1:0] pin_oe,
    output logic [NS+ND-1:0] pin_out,
    output logic [NS-1:0]    seg_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       wr_mask,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic [1:0]       cnt_tick,
    output logic             irq_hi,
    output logic             irq_lo
);
    localparam int NP = NS + ND;

    pin_ctrl_t [NP-1:0] ctrl;
    logic [NP-1:0] lvl, rise, fall;
    evt_t evt;

    gpio_pin_sync #(.NP(NP)) u_sync (
        .clk(clk), .rst(rst), .pin_raw(pin_in),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    gpio_cfg_regs #(.NS(NS), .ND(ND), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .pin_lvl(lvl), .ctrl(ctrl)
    );

    gpio_event_router #(.NP(NP)) u_router (
        .clk(clk), .rst(rst), .ctrl(ctrl), .rise(rise), .fall(fall),
        .evt_q(evt)
    );

    for (genvar p = 0; p < NP; p++) begin : g_pad
        assign pin_oe[p]  = !ctrl[p].seg && ctrl[p].dir;
        assign pin_out[p] = pin_oe[p] && ctrl[p].dout;
    end

    for (genvar s = 0; s < NS; s++) begin : g_seg
        assign seg_en[s] = ctrl[s].seg;
    end

    assign cnt_tick = {evt.cnt1, evt.cnt0};
    assign irq_hi   = evt.irq_hi;
    assign irq_lo   = evt.irq_lo;

    // R2: a pin handed to segment drive never has its driver enabled
    p_seg_no_oe_r2: assert property (@(posedge clk) disable iff (rst)
        (seg_en & pin_oe[NS-1:0]) == '0);

    // R3: the driven value is low whenever the driver is off
    p_out_gated_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/shared_gpio_mux_bench.sv
module shared_gpio_mux_bench;
    localparam int NS = 8;
    localparam int ND = 2;
    localparam int AW = 5;
    localparam int NP = NS + ND;
    localparam int NB = 2 * NS + ND;

    logic clk = 0;
    logic rst = 1;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe, pin_out;
    logic [NS-1:0] seg_en;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0, wr_mask = '0, rd_data;
    logic [1:0] cnt_tick;
    logic irq_hi, irq_lo;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    shared_gpio_mux #(.NS(NS), .ND(ND), .AW(AW)) u_shared_gpio_mux (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .seg_en(seg_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_tick(cnt_tick),
        .irq_hi(irq_hi), .irq_lo(irq_lo)
    );

    // ---------------- reference model ----------------
    logic [7:0] mem [NB];
    logic [NP-1:0] hist [$];
    logic [NP-1:0] exp_oe, exp_out;
    logic [NS-1:0] exp_seg;
    logic [7:0] exp_rd;
    logic [3:0] exp_evt;   // {cnt1, cnt0, irq_hi, irq_lo}

    function automatic logic [7:0] impl_of(int a);
        if (a < NS) return 8'hFF;
        if (a < NS + ND) return 8'h97;
        if (a < NB) return 8'h07;
        return 8'h00;
    endfunction

    function automatic void pin_attr(int p, output bit seg, output bit dir,
                                     output bit d, output int sel);
        if (p < NS) begin
            seg = mem[p][7]; dir = mem[p][3]; d = mem[p][0];
            sel = int'(mem[NS+ND+p][2:0]);
        end else begin
            seg = 0; dir = mem[p][7]; d = mem[p][4];
            sel = int'(mem[p][2:0]);
        end
    endfunction

    task automatic refresh_static(input logic [NP-1:0] lvl);
        bit seg, dir, d;
        int sel;
        int a;
        for (int p = 0; p < NP; p++) begin
            pin_attr(p, seg, dir, d, sel);
            exp_oe[p]  = !seg && dir;
            exp_out[p] = !seg && dir && d;
            if (p < NS) exp_seg[p] = seg;
        end
        a = int'(rd_addr);
        exp_rd = (a < NB) ? mem[a] : 8'h00;
        if (a < NS && !mem[a][7] && !mem[a][3]) exp_rd[0] = lvl[a];
        if (a >= NS && a < NS + ND && !mem[a][7]) exp_rd[4] = lvl[a];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NB; a++) mem[a] = 8'h00;
            hist.delete();
            for (int k = 0; k < 3; k++) hist.push_back('0);
            exp_evt = '0;
            refresh_static('0);
        end else begin
            bit seg, dir, d;
            int sel;
            bit r, f;
            exp_evt = '0;
            for (int p = 0; p < NP; p++) begin
                pin_attr(p, seg, dir, d, sel);
                r = hist[1][p] && !hist[2][p];
                f = !hist[1][p] && hist[2][p];
                if (!seg && !dir) begin
                    if (sel == 2 && r) exp_evt[2] = 1;
                    if (sel == 3 && r) exp_evt[3] = 1;
                    if (sel == 4 && r) exp_evt[1] = 1;
                    if (sel == 5 && r) exp_evt[0] = 1;
                    if (sel == 6 && f) exp_evt[1] = 1;
                    if (sel == 7 && f) exp_evt[0] = 1;
                end
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
            if (wr_en && int'(wr_addr) < NB) begin
                int a;
                logic [7:0] en;
                a = int'(wr_addr);
                en = wr_mask & impl_of(a);
                mem[a] = (mem[a] & ~en) | (wr_data & en);
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compared on every falling edge, before the driver moves inputs
    always @(negedge clk) begin
        if (rst) begin
            chk("R1", "oe", 16'(pin_oe), 16'(0));
            chk("R1", "out", 16'(pin_out), 16'(0));
            chk("R1", "events", 16'({cnt_tick, irq_hi, irq_lo}), 16'(0));
            chk("R1", "rd", 16'(rd_data), 16'(0));
        end else begin
            refresh_static(hist[1]);
            chk("R2 R3", "oe", 16'(pin_oe), 16'(exp_oe));
            chk("R3", "out", 16'(pin_out), 16'(exp_out));
            chk("R2", "seg_en", 16'(seg_en), 16'(exp_seg));
            chk("R4 R5", "rd", 16'(rd_data), 16'(exp_rd));
            chk("R6 R8 R9", "cnt_tick", 16'(cnt_tick), 16'(exp_evt[3:2]));
            chk("R7 R8 R9", "irq", 16'({irq_hi, irq_lo}), 16'(exp_evt[1:0]));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [7:0] d, input logic [7:0] m);
        step();
        wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_mask = m;
        step();
        wr_en = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (4) step();
        rst = 0;
        // R1: every byte reads zero after reset
        for (int a = 0; a < NB + 2; a++) begin
            step(); rd_addr = AW'(a);
        end
        // R3: shared pin 0 as output driving 1, selector 2 (blocked, R8)
        wr(0, 8'h09, 8'hFF);
        wr(NS + ND + 0, 8'hFA, 8'hFF);
        // R2: shared pin 1 to segment with pattern, selector 4 (blocked)
        wr(1, 8'h96, 8'hFF);
        wr(NS + ND + 1, 8'h04, 8'hFF);
        // R4: masked write clears only bits 2:1
        wr(1, 8'h00, 8'h06);
        step(); rd_addr = AW'(1);
        // R6 R7: selectors 2..7 on shared pins 2..7
        for (int p = 2; p < NS; p++) wr(NS + ND + p, 8'(p), 8'h07);
        // R3: dedicated pin 0 as output, data 1, selector 2 (blocked)
        wr(NS, 8'h92, 8'hFF);
        // R9: dedicated pin 1 input, selector 4, ORs with shared pin 4
        wr(NS + 1, 8'h04, 8'hFF);
        // R5 R6 R7 R9: toggle pins with varied patterns
        for (int c = 0; c < 300; c++) begin
            step();
            pin_in = NP'($urandom);
            rd_addr = AW'($urandom_range(0, NB + 1));
        end
        // R9: simultaneous rising edges on pins sharing irq_hi
        step(); pin_in = '0;
        repeat (4) step();
        pin_in[4] = 1; pin_in[NS+1] = 1;
        repeat (4) step();
        // R4 R8: random masked writes while pins move
        for (int c = 0; c < 300; c++) begin
            step();
            pin_in = NP'($urandom);
            rd_addr = AW'($urandom_range(0, NB + 1));
            if ($urandom_range(0, 2) == 0) begin
                wr_en = 1;
                wr_addr = AW'($urandom_range(0, NB + 1));
                wr_data = 8'($urandom);
                wr_mask = 8'($urandom);
            end else begin
                wr_en = 0;
            end
        end
        step(); wr_en = 0; pin_in = '0;
        repeat (6) step();
        // R1: reset again mid-run
        rst = 1;
        repeat (3) step();
        rst = 0;
        repeat (4) step();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule